// File: doc/BRIEF.md
# Timed Phase Sequencer with Shared Delay Routine

This block steps a control machine through a fixed run of timed phases after one start request. The phases are A, B, C and a final write phase. Each phase holds for a number of clock cycles that is set by a parameter. No phase has a compare-and-advance counter of its own. Every phase enters one shared delay routine, in the same way software calls a subroutine.

Each phase has a one-cycle calling state. That state writes two registers: the wait count and the state to resume at. It then jumps into the routine. The routine has three states: a start state that loads the countdown counter from the wait register, a wait state that decrements the counter, and an end state that jumps to the stored return state. After the write phase the routine returns to idle.

The block drives a one-hot phase output and a busy flag. A controller above it uses these outputs to time its own actions. Control pins are plain signals. The block has no data stream, so it has no valid/ready handshake.

Top module: `seqd_timed_seq`

## Requirements
- R1: When `rst_i` is high at a rising edge, the machine goes to idle and clears its countdown. From the following cycle `phase_o` is 0 and `busy_o` is 0. A later start then runs a full, correct sequence.
- R2: In idle, the machine stays idle for as long as `we_i` is 0. If `we_i` is 1 at a rising edge while idle, `phase_o` becomes 4'b0001 (phase A) in the cycle that follows that edge.
- R3: Phases run in the order A, B, C, write, each one exactly once per start. `phase_o` is one-hot: bit 0 is A, bit 1 is B, bit 2 is C and bit 3 is write. In idle all four bits are 0.
- R4: A phase whose duration parameter D is 3 or more keeps its `phase_o` bit high for exactly D consecutive cycles.
- R5: A phase whose duration parameter is 0, 1 or 2 still passes through the calling, start and end states. It therefore lasts exactly 3 cycles, and the countdown never wraps below zero.
- R6: `we_i` has no effect outside idle. Holding `we_i` high during any phase leaves every phase duration and the phase order unchanged.
- R7: `busy_o` is 1 exactly in the cycles where `phase_o` is not zero.
- R8: When the write phase ends, the machine returns to idle. If `we_i` is held at 1, idle lasts exactly one cycle before phase A starts again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| we_i | input | 1 | Start request; sampled only while idle |
| phase_o | output | 4 | One-hot current phase: bit0 A, bit1 B, bit2 C, bit3 write |
| busy_o | output | 1 | High whenever the machine is not idle |

## Verification
The two cases hardest to reach from the ports are the shortest phase and a reset that arrives inside a delay. In the shortest phase the routine skips its wait state entirely. A reset inside a delay leaves a loaded countdown and a pending return state behind. The default parameters give phase B a duration of 1, so every start passes through the skip path. The stimulus also asserts reset while phase B is active and then runs a fresh sequence, which shows that the abandoned count has no effect. A run with `we_i` held high tests that the input is ignored during phases and that idle lasts exactly one cycle between back-to-back sequences.

// File: rtl/seqd_pkg.sv
package seqd_pkg;

  typedef enum logic [2:0] {
    S_IDLE      = 3'd0,
    S_CALL_A    = 3'd1,
    S_CALL_B    = 3'd2,
    S_CALL_C    = 3'd3,
    S_CALL_W    = 3'd4,
    S_DLY_START = 3'd5,
    S_DLY_WAIT  = 3'd6,
    S_DLY_END   = 3'd7
  } seq_state_e;

  typedef enum logic [2:0] {
    PH_NONE = 3'd0,
    PH_A    = 3'd1,
    PH_B    = 3'd2,
    PH_C    = 3'd3,
    PH_W    = 3'd4
  } phase_e;

  localparam int NUM_PHASES = 4;
  // Calling state + delay start + delay end always run.
  localparam int FIXED_CYCLES = 3;

  function automatic int wait_cycles(input int dur);
    return (dur > FIXED_CYCLES) ? dur - FIXED_CYCLES : 0;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/seqd_dly_cnt.sv
module seqd_dly_cnt #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (dec_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == CW'(1));

endmodule

// File: rtl/seqd_phase_dec.sv
module seqd_phase_dec #(
  parameter int NPH = 4
) (
  input  seqd_pkg::phase_e ph_i,
  output logic [NPH-1:0]   onehot_o
);

  for (genvar i = 0; i < NPH; i++) begin : g_bit
    assign onehot_o[i] = (ph_i == seqd_pkg::phase_e'(3'(i + 1)));
  end

endmodule

// File: rtl/seqd_ctrl.sv
module seqd_ctrl
  import seqd_pkg::*;
#(
  parameter int DUR_A = 6,
  parameter int DUR_B = 1,
  parameter int DUR_C = 3,
  parameter int DUR_W = 10,
  parameter int CW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          we_i,
  input  logic          cnt_last_i,
  output logic          cnt_clr_o,
  output logic          cnt_load_o,
  output logic [CW-1:0] cnt_load_val_o,
  output logic          cnt_dec_o,
  output seq_state_e    state_o,
  output phase_e        phase_o
);

  localparam logic [CW-1:0] WAIT_A = CW'(wait_cycles(DUR_A));
  localparam logic [CW-1:0] WAIT_B = CW'(wait_cycles(DUR_B));
  localparam logic [CW-1:0] WAIT_C = CW'(wait_cycles(DUR_C));
  localparam logic [CW-1:0] WAIT_W = CW'(wait_cycles(DUR_W));

  seq_state_e    state_q, state_d;
  seq_state_e    ret_q, ret_d;
  logic [CW-1:0] dly_q, dly_d;
  phase_e        ph_q, ph_d;

  function automatic phase_e phase_of(input seq_state_e s);
    case (s)
      S_CALL_A: return PH_A;
      S_CALL_B: return PH_B;
      S_CALL_C: return PH_C;
      S_CALL_W: return PH_W;
      default:  return PH_NONE;
    endcase
  endfunction

  always_comb begin
    state_d        = state_q;
    ret_d          = ret_q;
    dly_d          = dly_q;
    cnt_clr_o      = 1'b0;
    cnt_load_o     = 1'b0;
    cnt_load_val_o = dly_q;
    cnt_dec_o      = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (we_i) begin
          state_d   = S_CALL_A;
          cnt_clr_o = 1'b1;
        end
      end
      S_CALL_A: begin
        dly_d   = WAIT_A;
        ret_d   = S_CALL_B;
        state_d = S_DLY_START;
      end
      S_CALL_B: begin
        dly_d   = WAIT_B;
        ret_d   = S_CALL_C;
        state_d = S_DLY_START;
      end
      S_CALL_C: begin
        dly_d   = WAIT_C;
        ret_d   = S_CALL_W;
        state_d = S_DLY_START;
      end
      S_CALL_W: begin
        dly_d   = WAIT_W;
        ret_d   = S_IDLE;
        state_d = S_DLY_START;
      end
      S_DLY_START: begin
        cnt_load_o = 1'b1;
        state_d    = (dly_q == '0) ? S_DLY_END : S_DLY_WAIT;
      end
      S_DLY_WAIT: begin
        if (cnt_last_i) state_d = S_DLY_END;
        else            cnt_dec_o = 1'b1;
      end
      S_DLY_END: begin
        state_d = ret_q;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    ph_d = ph_q;
    if (state_d == S_IDLE || state_d == S_CALL_A || state_d == S_CALL_B ||
        state_d == S_CALL_C || state_d == S_CALL_W) begin
      ph_d = phase_of(state_d);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= S_IDLE;
      ret_q   <= S_IDLE;
      dly_q   <= '0;
      ph_q    <= PH_NONE;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      dly_q   <= dly_d;
      ph_q    <= ph_d;
    end
  end

  assign state_o = state_q;
  assign phase_o = ph_q;

endmodule

// File: rtl/seqd_timed_seq.sv
module seqd_timed_seq
  import seqd_pkg::*;
#(
  parameter int DUR_A = 6,
  parameter int DUR_B = 1,
  parameter int DUR_C = 3,
  parameter int DUR_W = 10
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       we_i,
  output logic [3:0] phase_o,
  output logic       busy_o
);

  localparam int MAX_WAIT = wait_cycles(max4(DUR_A, DUR_B, DUR_C, DUR_W));
  localparam int CW       = $clog2(MAX_WAIT + 2);

  seq_state_e    state_q;
  phase_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic          cnt_last, cnt_clr, cnt_load, cnt_dec;
  logic [CW-1:0] cnt_load_val;

  seqd_ctrl #(
    .DUR_A(DUR_A), .DUR_B(DUR_B), .DUR_C(DUR_C), .DUR_W(DUR_W), .CW(CW)
  ) u_ctrl (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .we_i           (we_i),
    .cnt_last_i     (cnt_last),
    .cnt_clr_o      (cnt_clr),
    .cnt_load_o     (cnt_load),
    .cnt_load_val_o (cnt_load_val),
    .cnt_dec_o      (cnt_dec),
    .state_o        (state_q),
    .phase_o        (ph_q)
  );

  seqd_dly_cnt #(.CW(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .clr_i      (cnt_clr),
    .load_i     (cnt_load),
    .load_val_i (cnt_load_val),
    .dec_i      (cnt_dec),
    .cnt_o      (cnt_q),
    .last_o     (cnt_last)
  );

  seqd_phase_dec #(.NPH(NUM_PHASES)) u_dec (
    .ph_i     (ph_q),
    .onehot_o (phase_o)
  );

  assign busy_o = (state_q != S_IDLE);

endmodule

// File: rtl/seqd_timed_seq_chk.sv
module seqd_timed_seq_chk
  import seqd_pkg::*;
#(
  parameter int DUR_A = 6,
  parameter int DUR_B = 1,
  parameter int DUR_C = 3,
  parameter int DUR_W = 10,
  parameter int CW    = 4
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          we_i,
  input logic [3:0]    phase_i,
  input logic          busy_i,
  input seq_state_e    state_i,
  input logic [CW-1:0] cnt_i
);

  function automatic int exp_len(input logic [3:0] ph);
    int d;
    case (ph)
      4'b0001: d = DUR_A;
      4'b0010: d = DUR_B;
      4'b0100: d = DUR_C;
      default: d = DUR_W;
    endcase
    return (d < FIXED_CYCLES) ? FIXED_CYCLES : d;
  endfunction

  logic [3:0]  prev_ph;
  logic [15:0] run_len;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_ph <= '0;
      run_len <= 16'd1;
    end else if (phase_i != prev_ph) begin
      prev_ph <= phase_i;
      run_len <= 16'd1;
    end else if (run_len != 16'hFFFF) begin
      run_len <= run_len + 16'd1;
    end
  end

  a_r2_start: assert property (@(posedge clk_i) disable iff (rst_i)
    (!busy_i && we_i) |=> (phase_i == 4'b0001));
  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (!busy_i && !we_i) |=> !busy_i);
  a_r3_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(phase_i));
  a_r3_order_b: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(phase_i[1]) |-> $past(phase_i[0]));
  a_r3_order_c: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(phase_i[2]) |-> $past(phase_i[1]));
  a_r3_order_w: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(phase_i[3]) |-> $past(phase_i[2]));
  a_r4_duration: assert property (@(posedge clk_i) disable iff (rst_i)
    (prev_ph != 4'b0000 && phase_i != prev_ph) |-> (32'(run_len) == exp_len(prev_ph)));
  a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_i == S_DLY_WAIT) |-> (cnt_i != '0));
  a_r6_we_ignored: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_i && we_i && !phase_i[0]) |=> !phase_i[0]);
  a_r7_busy: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_i == (phase_i != 4'b0000));
  a_r8_return_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(busy_i) |-> $past(phase_i[3]));

endmodule

bind seqd_timed_seq seqd_timed_seq_chk #(
  .DUR_A(DUR_A), .DUR_B(DUR_B), .DUR_C(DUR_C), .DUR_W(DUR_W), .CW(CW)
) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .we_i    (we_i),
  .phase_i (phase_o),
  .busy_i  (busy_o),
  .state_i (state_q),
  .cnt_i   (cnt_q)
);

// File: tb/tb_seqd_timed_seq.sv
module tb_seqd_timed_seq;

  localparam int DA = 6;
  localparam int DB = 1;
  localparam int DC = 3;
  localparam int DW = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       we  = 1'b0;
  logic [3:0] phase;
  logic       busy;

  always #4 clk = ~clk;

  seqd_timed_seq #(.DUR_A(DA), .DUR_B(DB), .DUR_C(DC), .DUR_W(DW)) dut (
    .clk_i(clk), .rst_i(rst), .we_i(we), .phase_o(phase), .busy_o(busy)
  );

  typedef struct {
    logic [3:0] ph;
    int         len;
    string      req;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int errors = 0;

  function automatic int dur(input int d);
    return (d < 3) ? 3 : d;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_item(input logic [3:0] ph, input int d);
    item_t it;
    it.ph  = ph;
    it.len = dur(d);
    it.req = (d < 3) ? "R5" : "R4";
    exp_q.push_back(it);
  endtask

  task automatic push_run();
    push_item(4'b0001, DA);
    push_item(4'b0010, DB);
    push_item(4'b0100, DC);
    push_item(4'b1000, DW);
  endtask

  // Monitor: tracks runs of a non-zero phase and scores them.
  logic [3:0] cur_ph = '0;
  int         cur_len = 0;

  always @(negedge clk) begin
    if (rst) begin
      cur_ph  = '0;
      cur_len = 0;
    end else begin
      check(busy == (phase != 4'b0000), "R7", "busy vs phase", int'(busy), int'(phase != 0));
      if ($countones(phase) > 1) check(1'b0, "R3", "phase not one-hot", int'(phase), 0);
      if (phase != cur_ph) begin
        if (cur_ph != 4'b0000) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R3", "unexpected phase run", int'(cur_ph), 0);
          end else begin
            item_t it;
            it = exp_q.pop_front();
            check(cur_ph == it.ph, "R3", "phase order", int'(cur_ph), int'(it.ph));
            check(cur_len == it.len, it.req, "phase length", cur_len, it.len);
          end
        end
        cur_ph  = phase;
        cur_len = 1;
      end else begin
        cur_len++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(phase == 4'b0000, "R1", "phase in reset", int'(phase), 0);
    check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    rst = 1'b0;

    // R2: idle held without a start
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(busy == 1'b0 && phase == 4'b0000, "R2", "idle hold", int'(phase), 0);
    end

    // R2/R3/R4/R5: single start pulse
    push_run();
    we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    check(phase == 4'b0001, "R2", "phase A after start", int'(phase), 1);
    while (busy) @(negedge clk);
    check(phase == 4'b0000, "R8", "idle after write", int'(phase), 0);
    @(negedge clk);
    check(exp_q.size() == 0, "R3", "all phases seen", exp_q.size(), 0);

    // R6/R8: we held high through two back-to-back sequences
    push_run();
    push_run();
    we = 1'b1;
    @(negedge clk);
    while (phase != 4'b1000) @(negedge clk);
    while (phase == 4'b1000) @(negedge clk);
    check(phase == 4'b0000, "R8", "idle between runs", int'(phase), 0);
    @(negedge clk);
    check(phase == 4'b0001, "R8", "restart after one idle cycle", int'(phase), 1);
    we = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R6", "durations unchanged with we held", exp_q.size(), 0);

    // R1: reset inside phase B, then a fresh run
    push_run();
    we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    while (phase != 4'b0010) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(phase == 4'b0000, "R1", "phase after mid-run reset", int'(phase), 0);
    check(busy == 1'b0, "R1", "busy after mid-run reset", int'(busy), 0);
    exp_q.delete();
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R2", "idle after reset release", int'(busy), 0);
    push_run();
    we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    check(phase == 4'b0001, "R1", "clean restart after reset", int'(phase), 1);
    while (busy) @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R1", "full run after reset", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule